// File: doc/BRIEF.md
# Floating-point exception accrual unit

This block sits beside a floating-point datapath and keeps a sticky summary of the exceptions raised by the operations that have finished since software last cleared it. When the datapath pulses its completion strobe, the block merges that operation's eight exception status bits into five accrued flags. Several status conditions fold into one accrued flag. An underflow counts only when the result was also inexact.

In the same cycle the block forms the trap requests for the completed operation. Each exception raises its own request when its status bit and its enable bit are both set. A combined inexact request also fires when overflow or an inexact result meets the inexact-result enable, or when an inexact decimal input meets its own enable. Requests are registered and last one cycle per completed operation. Software can overwrite the accrued flags at any time, which also serves to clear them.

Top module: `fpx_accrue_unit`

## Requirements
- R1: Status and enable vectors use these bit positions: 0 unordered-compare, 1 signaling NaN, 2 operand error, 3 overflow, 4 underflow, 5 divide-by-zero, 6 inexact result, 7 inexact decimal input. On a completed operation the invalid flag (accrued bit 0) is ORed with status[0] | status[1] | status[2].
- R2: The underflow flag (accrued bit 2) is set on a completed operation only when status[4] and status[6] are both 1. Otherwise it keeps its value.
- R3: The inexact flag (accrued bit 4) is ORed with status[3] | status[6] | status[7] on a completed operation.
- R4: The overflow flag (accrued bit 1) is ORed with status[3], and the divide-by-zero flag (accrued bit 3) is ORed with status[5], on a completed operation.
- R5: While op_done is 0 and acc_wr is 0, the accrued flags hold their value whatever the status inputs are.
- R6: When acc_wr is 1, the accrued flags take acc_wdata on the next edge, even if op_done is also 1 in that cycle.
- R7: One cycle after an edge with op_done high, trap_req[i] equals status[i] & trap_en[i]. After any edge with op_done low, trap_req is 0.
- R8: One cycle after an edge with op_done high, trap_inex equals ((status[3] | status[6]) & trap_en[6]) | (status[7] & trap_en[7]). After an edge with op_done low, trap_inex is 0.
- R9: Synchronous active-high reset clears the accrued flags, trap_req and trap_inex.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_done | input | 1 | One-cycle strobe: an operation completed this cycle |
| op_status | input | 8 | Exception status of the completing operation |
| trap_en | input | 8 | Trap enable per exception |
| acc_wr | input | 1 | Software write strobe for the accrued flags |
| acc_wdata | input | 5 | Value written to the accrued flags |
| acc_flags | output | 5 | Accrued flags: 0 invalid, 1 overflow, 2 underflow, 3 divide-by-zero, 4 inexact |
| trap_req | output | 8 | Registered per-exception trap requests |
| trap_inex | output | 1 | Registered combined inexact trap request |

## Verification
The properties take op_status and trap_en to be meaningful only in cycles where op_done is high. They make no assumption about these inputs elsewhere and expect them to have no effect then. The stimulus drives random status values in idle cycles too, so that the no-effect requirement is actually exercised. Software writes arrive at arbitrary cycles, including cycles with a completion. The properties allow this, and the stimulus places several such collisions on purpose.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int ST_W  = 8;
  localparam int ACC_W = 5;

  // status / enable bit positions
  localparam int S_UNORD = 0;
  localparam int S_SNAN  = 1;
  localparam int S_OPERR = 2;
  localparam int S_OVFL  = 3;
  localparam int S_UNFL  = 4;
  localparam int S_DZ    = 5;
  localparam int S_INEXR = 6;
  localparam int S_INEXD = 7;

  // accrued flag positions
  localparam int A_IOP  = 0;
  localparam int A_OVFL = 1;
  localparam int A_UNFL = 2;
  localparam int A_DZ   = 3;
  localparam int A_INEX = 4;
endpackage

// File: rtl/fpx_merge.sv
module fpx_merge
  import fpx_pkg::*;
(
  input  logic [ST_W-1:0]  status,
  output logic [ACC_W-1:0] contrib
);
  always_comb begin
    contrib         = '0;
    contrib[A_IOP]  = status[S_UNORD] | status[S_SNAN] | status[S_OPERR];
    contrib[A_OVFL] = status[S_OVFL];
    contrib[A_UNFL] = status[S_UNFL] & status[S_INEXR];
    contrib[A_DZ]   = status[S_DZ];
    contrib[A_INEX] = status[S_INEXD] | status[S_INEXR] | status[S_OVFL];
  end
endmodule

// File: rtl/fpx_sticky.sv
module fpx_sticky #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_en,
  input  logic [W-1:0] set_bits,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                      q[i] <= 1'b0;
      else if (wr)                  q[i] <= wdata[i];
      else if (set_en && set_bits[i]) q[i] <= 1'b1;
    end
  end
endmodule

// File: rtl/fpx_trapgen.sv
module fpx_trapgen
  import fpx_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  logic [ST_W-1:0] status,
  input  logic [ST_W-1:0] enable,
  output logic [ST_W-1:0] req,
  output logic            inex_req
);
  logic inex_comb;

  assign inex_comb = ((status[S_OVFL] | status[S_INEXR]) & enable[S_INEXR])
                   | (status[S_INEXD] & enable[S_INEXD]);

  for (genvar i = 0; i < ST_W; i++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req[i] <= 1'b0;
      else     req[i] <= fire & status[i] & enable[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) inex_req <= 1'b0;
    else     inex_req <= fire & inex_comb;
  end
endmodule

// File: rtl/fpx_accrue_unit.sv
module fpx_accrue_unit
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             op_done,
  input  logic [ST_W-1:0]  op_status,
  input  logic [ST_W-1:0]  trap_en,
  input  logic             acc_wr,
  input  logic [ACC_W-1:0] acc_wdata,
  output logic [ACC_W-1:0] acc_flags,
  output logic [ST_W-1:0]  trap_req,
  output logic             trap_inex
);
  logic [ACC_W-1:0] contrib;

  fpx_merge u_merge (
    .status  (op_status),
    .contrib (contrib)
  );

  fpx_sticky #(.W(ACC_W)) u_sticky (
    .clk      (clk),
    .rst      (rst),
    .set_en   (op_done),
    .set_bits (contrib),
    .wr       (acc_wr),
    .wdata    (acc_wdata),
    .q        (acc_flags)
  );

  fpx_trapgen u_trap (
    .clk      (clk),
    .rst      (rst),
    .fire     (op_done),
    .status   (op_status),
    .enable   (trap_en),
    .req      (trap_req),
    .inex_req (trap_inex)
  );
endmodule

// File: rtl/fpx_accrue_chk.sv
module fpx_accrue_chk
  import fpx_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             op_done,
  input logic [ST_W-1:0]  op_status,
  input logic [ST_W-1:0]  trap_en,
  input logic             acc_wr,
  input logic [ACC_W-1:0] acc_wdata,
  input logic [ACC_W-1:0] acc_flags,
  input logic [ST_W-1:0]  trap_req,
  input logic             trap_inex
);
  p_iop_accrue_r1: assert property (@(posedge clk) disable iff (rst)
    (op_done && !acc_wr && (op_status[S_UNORD] || op_status[S_SNAN] || op_status[S_OPERR]))
    |=> acc_flags[A_IOP]);

  p_unfl_gate_r2: assert property (@(posedge clk) disable iff (rst)
    (!acc_wr && !acc_flags[A_UNFL] && !(op_done && op_status[S_UNFL] && op_status[S_INEXR]))
    |=> !acc_flags[A_UNFL]);

  p_inex_accrue_r3: assert property (@(posedge clk) disable iff (rst)
    (op_done && !acc_wr && (op_status[S_OVFL] || op_status[S_INEXR] || op_status[S_INEXD]))
    |=> acc_flags[A_INEX]);

  p_ovfl_dz_r4: assert property (@(posedge clk) disable iff (rst)
    (op_done && !acc_wr && op_status[S_OVFL] && op_status[S_DZ])
    |=> (acc_flags[A_OVFL] && acc_flags[A_DZ]));

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!op_done && !acc_wr) |=> $stable(acc_flags));

  p_write_wins_r6: assert property (@(posedge clk) disable iff (rst)
    acc_wr |=> (acc_flags == $past(acc_wdata)));

  p_trap_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    !op_done |=> (trap_req == '0));

  p_trap_match_r7: assert property (@(posedge clk) disable iff (rst)
    op_done |=> (trap_req == ($past(op_status) & $past(trap_en))));

  p_inex_trap_r8: assert property (@(posedge clk) disable iff (rst)
    (op_done && op_status[S_INEXD] && trap_en[S_INEXD]) |=> trap_inex);

  p_inex_idle_r8: assert property (@(posedge clk) disable iff (rst)
    !op_done |=> !trap_inex);

  p_sticky_r1: assert property (@(posedge clk) disable iff (rst)
    !acc_wr |=> ((acc_flags & $past(acc_flags)) == $past(acc_flags)));
endmodule

bind fpx_accrue_unit fpx_accrue_chk u_chk (.*);

// File: tb/fpx_accrue_unit_test.sv
`timescale 1ns/1ps
module fpx_accrue_unit_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_done = 1'b0;
  logic [7:0] op_status = '0;
  logic [7:0] trap_en = '0;
  logic       acc_wr = 1'b0;
  logic [4:0] acc_wdata = '0;
  logic [4:0] acc_flags;
  logic [7:0] trap_req;
  logic       trap_inex;

  int checks = 0;
  int fails  = 0;
  logic [4:0] model = '0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  fpx_accrue_unit uut (.*);

  function automatic logic [4:0] merge_f(input logic [7:0] s);
    logic [4:0] m;
    m[0] = s[0] | s[1] | s[2];
    m[1] = s[3];
    m[2] = s[4] & s[6];
    m[3] = s[5];
    m[4] = s[3] | s[6] | s[7];
    return m;
  endfunction

  function automatic logic inex_f(input logic [7:0] s, input logic [7:0] e);
    return ((s[3] | s[6]) & e[6]) | (s[7] & e[7]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle at the negedge, then check at the following negedge.
  task automatic step(input logic d, input logic [7:0] s, input logic [7:0] e,
                      input logic w, input logic [4:0] wd);
    logic [4:0] m;
    logic [7:0] exp_tr;
    logic       exp_ti;
    op_done = d; op_status = s; trap_en = e; acc_wr = w; acc_wdata = wd;
    if (w)      model = wd;
    else if (d) model = model | merge_f(s);
    exp_tr = d ? (s & e) : 8'h00;
    exp_ti = d ? inex_f(s, e) : 1'b0;
    @(posedge clk);
    @(negedge clk);
    m = acc_flags;
    check("R1", m[0], model[0]);
    check("R2", m[2], model[2]);
    check("R3", m[4], model[4]);
    check("R4", {m[3], m[1]}, {model[3], model[1]});
    if (!d && !w) check("R5", m, model);
    if (w)        check("R6", m, wd);
    check("R7", trap_req, exp_tr);
    check("R8", trap_inex, exp_ti);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R9", acc_flags, 5'd0);
    check("R9", trap_req, 8'd0);
    check("R9", trap_inex, 1'b0);

    // R2: underflow alone does not accrue, with inexact it does
    step(1, 8'h10, 8'hFF, 0, '0);
    step(1, 8'h50, 8'h00, 0, '0);
    // R5: idle status ignored
    step(0, 8'hFF, 8'hFF, 0, '0);
    // R6: write beats completion
    step(1, 8'hFF, 8'hFF, 1, 5'h00);
    step(1, 8'h2F, 8'h00, 1, 5'h15);
    step(0, 8'h00, 8'h00, 1, 5'h00);
    // R8: overflow with inexact-result enable only; decimal with own enable
    step(1, 8'h08, 8'h40, 0, '0);
    step(1, 8'h80, 8'h80, 0, '0);
    step(1, 8'h80, 8'h40, 0, '0);
    // R1: persistence across clean operations
    step(1, 8'h02, 8'h00, 0, '0);
    step(1, 8'h00, 8'hFF, 0, '0);
    step(1, 8'h00, 8'h00, 0, '0);

    // every status pattern, periodic clear
    for (int i = 0; i < 256; i++) begin
      logic [7:0] en;
      en = 8'($urandom);
      step(1, 8'(i), en, (i % 16) == 0, 5'h00);
    end

    // random mix
    for (int k = 0; k < 1500; k++) begin
      logic d, w;
      d = ($urandom % 3) != 0;
      w = ($urandom % 20) == 0;
      step(d, 8'($urandom), 8'($urandom), w, 5'($urandom));
    end

    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R9", acc_flags, 5'd0);
    check("R9", trap_req, 8'd0);

    done_flag = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule